// File: doc/BRIEF.md
# Capture/Compare Timer with Overflow Flag

This block holds a 16-bit counter that advances on every clock and never stops. Four channels, numbered 4 to 7, each watch that counter. In capture mode a channel records the counter when its input pin shows a chosen transition. In compare mode a channel raises a match flag when the counter equals its stored value, and it updates its output pin. When the counter rolls over from its top value back to zero, a separate sticky overflow flag is set. A small register bus gives access to the counter, to the channel registers, to the configuration and to both flag registers.

Software clears a flag by writing a one to its bit. As a faster option, a control bit lets any access to the counter address clear the overflow flag. Two interrupt lines are driven: one for the channels and one for the overflow. Each is the OR of the flags it covers, masked by their enables. The channel input pins may be asynchronous to the clock.

Top module: `cct_timer`

## Requirements
- R1: The counter is 16 bits wide, reads as 0 just after reset, and increases by one on each clock, wrapping to 0. A read of address 0 returns the count present on the edge that samples the read. A write to address 0 leaves the count unchanged.
- R2: Address 7 reads the overflow flag in bit 7, and all of its other bits read as 0. The flag sets on the edge where the counter goes from 0xFFFF to 0x0000.
- R3: A write to address 6 (channel flags) or to address 7 (overflow flag) clears every flag whose bit is written as 1. Bits written as 0 leave their flags unchanged.
- R4: When control bit 0 (address 1) is 1, any read or write of address 0 clears the overflow flag. When control bit 0 is 0, access to the counter leaves the overflow flag unchanged. In both cases the channel flags are not affected.
- R5: A channel with its mode bit at 0 is in capture mode. The mode bits are bit 4+n of address 2, for channel slot n = 0..3, which are channels 4..7. Edge field bits [2n+1:2n] of address 3 select the edge: 01 rising, 10 falling, 11 both. On a selected edge the channel register loads the counter and sets flag bit 4+n of address 6. The value loaded is the count present when the new pin level was first sampled, plus two.
- R6: Edge field 00 disables capture: pin transitions change neither the channel register nor its flag.
- R7: A channel with its mode bit at 1 is in compare mode. When the counter equals the channel register, flag bit 4+n of address 6 is set on that edge.
- R8: In compare mode, action field bits [2n+1:2n] of address 4 set what happens to output pin n on a match: 00 no change, 01 toggle, 10 drive 0, 11 drive 1. At all other times the outputs hold their values, and they are 0 after reset.
- R9: If a flag is set by its event and cleared by a bus write on the same edge, the flag ends up set.
- R10: The channel registers are at addresses 8+n. They can be read at any time, can be written from the bus, and read as 0 after reset.
- R11: `irq_ch` is the OR over channels of each flag ANDed with its enable bit (bit 4+n of address 5). `irq_ovf` is the overflow flag ANDed with control bit 1.
- R12: Read data appears on `bus_rdata` one clock after the read strobe, with `bus_rvalid` high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ch_in | input | 4 | Channel input pins, slot n is channel 4+n |
| ch_out | output | 4 | Channel output pins |
| irq_ch | output | 1 | Channel interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The hardest cases depend on time. An overflow needs the full 65,536-count span to pass. The set-wins case needs a flag-clear write to land on the exact edge where a compare match occurs. The bench reads the counter once and from then on models the count on its own, so it knows the count at every falling edge. It then waits for the counter to wrap twice: once to test clearing by write-one and by counter reads with fast clear off, and once to test clearing by a counter read with fast clear on. It also places the flag-clear write on the falling edge where the modelled count equals the compare value.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h1;
  localparam logic [ADDR_W-1:0] A_MODE = 4'h2;
  localparam logic [ADDR_W-1:0] A_EDGE = 4'h3;
  localparam logic [ADDR_W-1:0] A_ACT  = 4'h4;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'h5;
  localparam logic [ADDR_W-1:0] A_FLG1 = 4'h6;
  localparam logic [ADDR_W-1:0] A_FLG2 = 4'h7;
  localparam logic [ADDR_W-1:0] A_CHAN = 4'h8;

  localparam int CH_BIT0   = 4;  // slot n lives at bit CH_BIT0+n
  localparam int OVF_BIT   = 7;
  localparam int FCLR_BIT  = 0;
  localparam int OVFIE_BIT = 1;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // Set event for the overflow flag: this edge takes the count to zero.
  assign wrap = &cnt;
endmodule

// File: rtl/cct_flags.sv
module cct_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_d;
  logic         flags_en;

  always_comb begin
    flags_en = (|set) | (|clr);
    // Clear first, then OR in set: a same-cycle event keeps the flag.
    flags_d  = (flags & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_d;
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_mode,
  input  edge_sel_e        edge_sel,
  input  cmp_act_e         act,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             pin_in,
  output logic [CNT_W-1:0] value,
  output logic             event_o,
  output logic             pin_out
);
  localparam int SYNC_N = 3;  // two sync stages plus one history stage

  logic [SYNC_N-1:0] smp;
  logic              rise, fall, edge_hit;
  logic              cap_hit, cmp_hit;
  logic              value_en;
  logic [CNT_W-1:0]  value_d;
  logic              out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[SYNC_N-2:0], pin_in};
  end

  always_comb begin
    rise = smp[SYNC_N-2] & ~smp[SYNC_N-1];
    fall = ~smp[SYNC_N-2] & smp[SYNC_N-1];
    unique case (edge_sel)
      EDGE_OFF:  edge_hit = 1'b0;
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_ANY:  edge_hit = rise | fall;
    endcase
    cap_hit  = ~cmp_mode & edge_hit;
    cmp_hit  = cmp_mode & (cnt == value);
    event_o  = cap_hit | cmp_hit;
    value_en = load_en | cap_hit;
    value_d  = load_en ? load_val : cnt;
    unique case (act)
      ACT_NONE:   out_d = pin_out;
      ACT_TOGGLE: out_d = ~pin_out;
      ACT_CLEAR:  out_d = 1'b0;
      ACT_SET:    out_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (value_en) value <= value_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_out <= 1'b0;
    else if (cmp_hit) pin_out <= out_d;
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [NCH-1:0]    ch_in,
  output logic [NCH-1:0]    ch_out,
  output logic              irq_ch,
  output logic              irq_ovf
);
  localparam int CFG_W = 2 * NCH;

  // Reset: asserted at once, released two clocks later.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Counter
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  // Decode
  logic wr_ctrl, wr_mode, wr_edge, wr_act, wr_ien, wr_flg1, wr_flg2, cnt_touch;

  always_comb begin
    wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    wr_mode   = bus_wr && (bus_addr == A_MODE);
    wr_edge   = bus_wr && (bus_addr == A_EDGE);
    wr_act    = bus_wr && (bus_addr == A_ACT);
    wr_ien    = bus_wr && (bus_addr == A_IEN);
    wr_flg1   = bus_wr && (bus_addr == A_FLG1);
    wr_flg2   = bus_wr && (bus_addr == A_FLG2);
    cnt_touch = (bus_wr || bus_rd) && (bus_addr == A_CNT);
  end

  // Configuration registers
  logic [1:0]       ctrl_q;
  logic [NCH-1:0]   mode_q, ien_q;
  logic [CFG_W-1:0] edge_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
      if (wr_mode) mode_q <= bus_wdata[CH_BIT0 +: NCH];
      if (wr_ien)  ien_q  <= bus_wdata[CH_BIT0 +: NCH];
      if (wr_edge) edge_q <= bus_wdata[CFG_W-1:0];
      if (wr_act)  act_q  <= bus_wdata[CFG_W-1:0];
    end
  end

  // Channels
  logic [CNT_W-1:0] ch_val [NCH];
  logic [NCH-1:0]   ch_evt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(int'(A_CHAN) + i);
    logic load;
    assign load = bus_wr && (bus_addr == CH_ADDR);

    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cnt      (cnt),
      .cmp_mode (mode_q[i]),
      .edge_sel (edge_sel_e'(edge_q[2*i +: 2])),
      .act      (cmp_act_e'(act_q[2*i +: 2])),
      .load_en  (load),
      .load_val (bus_wdata),
      .pin_in   (ch_in[i]),
      .value    (ch_val[i]),
      .event_o  (ch_evt[i]),
      .pin_out  (ch_out[i])
    );
  end

  // Flags
  logic [NCH-1:0] flg1, flg1_clr;
  logic [0:0]     flg2, flg2_clr, ovf_set;

  always_comb begin
    flg1_clr    = wr_flg1 ? bus_wdata[CH_BIT0 +: NCH] : '0;
    flg2_clr[0] = (wr_flg2 && bus_wdata[OVF_BIT]) || (ctrl_q[FCLR_BIT] && cnt_touch);
    ovf_set[0]  = wrap;
  end

  cct_flags #(.W(NCH)) u_flg1 (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (ch_evt),
    .clr   (flg1_clr),
    .flags (flg1)
  );

  cct_flags #(.W(1)) u_flg2 (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (ovf_set),
    .clr   (flg2_clr),
    .flags (flg2)
  );

  // Read path
  function automatic logic [7:0] place_ch(input logic [NCH-1:0] v);
    logic [7:0] r;
    r = '0;
    r[CH_BIT0 +: NCH] = v;
    return r;
  endfunction

  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CNT:  rd_mux = cnt;
      A_CTRL: rd_mux = CNT_W'(ctrl_q);
      A_MODE: rd_mux = CNT_W'(place_ch(mode_q));
      A_EDGE: rd_mux = CNT_W'(edge_q);
      A_ACT:  rd_mux = CNT_W'(act_q);
      A_IEN:  rd_mux = CNT_W'(place_ch(ien_q));
      A_FLG1: rd_mux = CNT_W'(place_ch(flg1));
      A_FLG2: rd_mux = CNT_W'({flg2[0], 7'b0});
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (bus_addr == ADDR_W'(int'(A_CHAN) + i)) rd_mux = ch_val[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // Interrupts
  assign irq_ch  = |(flg1 & ien_q);
  assign irq_ovf = flg2[0] & ctrl_q[OVFIE_BIT];
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf_flag,
  input logic [NCH-1:0]    flg1,
  input logic [NCH-1:0]    ch_evt,
  input logic [NCH-1:0]    mode,
  input logic              fclr_en,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_ovf_bit,
  input logic              bus_rvalid,
  input logic [NCH-1:0]    ch_out,
  input logic              irq_ch,
  input logic              irq_ovf
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1) |=> ovf_flag);

  a_r3_ovf_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |->
      $past(bus_wr && bus_addr == A_FLG2 && wr_ovf_bit) ||
      $past(fclr_en && (bus_wr || bus_rd) && bus_addr == A_CNT));

  a_r4_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fclr_en && bus_rd && bus_addr == A_CNT && cnt != '1) |=> !ovf_flag);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt != '0) |=> ((flg1 & $past(ch_evt)) == $past(ch_evt)));

  for (genvar i = 0; i < NCH; i++) begin : g_hold
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[i] |=> $stable(ch_out[i]));
  end

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flg1 == '0 && !ovf_flag) |-> (!irq_ch && !irq_ovf));

  a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_rvalid == $past(bus_rd));
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .cnt        (cnt),
  .ovf_flag   (flg2[0]),
  .flg1       (flg1),
  .ch_evt     (ch_evt),
  .mode       (mode_q),
  .fclr_en    (ctrl_q[cct_pkg::FCLR_BIT]),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .wr_ovf_bit (bus_wdata[cct_pkg::OVF_BIT]),
  .bus_rvalid (bus_rvalid),
  .ch_out     (ch_out),
  .irq_ch     (irq_ch),
  .irq_ovf    (irq_ovf)
);

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
module cct_timer_bench;
  localparam logic [3:0] AD_CNT = 4'h0, AD_CTRL = 4'h1, AD_MODE = 4'h2, AD_EDGE = 4'h3,
                         AD_ACT = 4'h4, AD_IEN = 4'h5, AD_FLG1 = 4'h6, AD_FLG2 = 4'h7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  ch_in = '0;
  logic [3:0]  ch_out;
  logic        irq_ch, irq_ovf;

  cct_timer u_cct_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ch_in(ch_in), .ch_out(ch_out), .irq_ch(irq_ch), .irq_ovf(irq_ovf)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // Bench model of the counter: tick counts edges, off aligns it once.
  logic [31:0] tick = '0;
  logic [15:0] off = '0;
  always @(posedge clk) tick <= tick + 1;
  function automatic logic [15:0] mcnt();
    return tick[15:0] + off;
  endfunction

  // Scoreboard
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (bus_rvalid && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s read: actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pin: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (mcnt() != v) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] c, d, v;
    idle(3);
    // R8 R11 R12: reset state at the pins
    chk({12'b0, ch_out}, 16'h0, "R8");
    chk({14'b0, irq_ch, irq_ovf}, 16'h0, "R11");
    chk({15'b0, bus_rvalid}, 16'h0, "R12");
    rst_n = 1'b1;
    idle(4);

    // Align the model counter with one direct read.
    bus_addr = AD_CNT; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    off = bus_rdata + 16'd1 - tick[15:0];
    chk({15'b0, bus_rvalid}, 16'h1, "R12");
    idle(1);
    chk({15'b0, bus_rvalid}, 16'h0, "R12");

    bus_read(AD_CNT, mcnt(), "R1");
    idle(7);
    bus_read(AD_CNT, mcnt(), "R1");
    bus_write(AD_CNT, 16'h1234);
    bus_read(AD_CNT, mcnt(), "R1 write ignored");
    for (int i = 0; i < 4; i++) bus_read(4'(8 + i), 16'h0000, "R10 reset");
    bus_read(AD_FLG1, 16'h0000, "R3 reset");
    bus_read(AD_FLG2, 16'h0000, "R2 reset");

    // Capture: slot0 rise, slot1 fall, slot2 both, slot3 disabled
    bus_write(AD_MODE, 16'h0000);
    bus_write(AD_EDGE, 16'h0039);
    c = mcnt();
    ch_in = 4'b1111;
    idle(5);
    bus_read(AD_FLG1, 16'h0050, "R5 rise flags");
    bus_read(4'h8, c + 16'd2, "R5 rise value");
    bus_read(4'hA, c + 16'd2, "R5 both value");
    bus_read(4'h9, 16'h0000, "R5 fall not on rise");
    bus_read(4'hB, 16'h0000, "R6");
    d = mcnt();
    ch_in = 4'b0000;
    idle(5);
    bus_read(AD_FLG1, 16'h0070, "R5 fall flags");
    bus_read(4'h9, d + 16'd2, "R5 fall value");
    bus_read(4'hA, d + 16'd2, "R5 both second");
    bus_read(4'h8, c + 16'd2, "R5 rise held");
    bus_read(4'hB, 16'h0000, "R6 disabled");

    // R11: interrupt masking
    chk({15'b0, irq_ch}, 16'h0, "R11 all masked");
    bus_write(AD_IEN, 16'h0080);
    chk({15'b0, irq_ch}, 16'h0, "R11 flag clear");
    bus_write(AD_IEN, 16'h0010);
    chk({15'b0, irq_ch}, 16'h1, "R11 enabled");

    // R3: write one clears, write zero keeps
    bus_write(AD_FLG1, 16'h0050);
    bus_read(AD_FLG1, 16'h0020, "R3 partial clear");
    chk({15'b0, irq_ch}, 16'h0, "R11 after clear");
    bus_write(AD_FLG1, 16'h0000);
    bus_read(AD_FLG1, 16'h0020, "R3 zero write");
    bus_write(AD_FLG1, 16'h0020);

    // Compare: slot0 toggle, slot1 set, slot2 clear, slot3 none
    bus_write(AD_MODE, 16'h00F0);
    bus_write(AD_ACT, 16'h002D);
    v = mcnt() + 16'd30;
    for (int i = 0; i < 4; i++) bus_write(4'(8 + i), v);
    bus_read(AD_FLG1, 16'h0000, "R7 before match");
    wait_cnt(v + 16'd1);
    chk({12'b0, ch_out}, 16'h0003, "R8 first match");
    bus_read(AD_FLG1, 16'h00F0, "R7 match flags");
    bus_write(AD_ACT, 16'h0039);
    v = mcnt() + 16'd20;
    for (int i = 0; i < 4; i++) bus_write(4'(8 + i), v);
    wait_cnt(v);
    chk({12'b0, ch_out}, 16'h0003, "R8 hold");
    wait_cnt(v + 16'd1);
    chk({12'b0, ch_out}, 16'h0004, "R8 second match");

    // R9: clear write on the match edge
    bus_write(AD_FLG1, 16'h00F0);
    bus_read(AD_FLG1, 16'h0000, "R3 all cleared");
    v = mcnt() + 16'd20;
    bus_write(4'h8, v);
    wait_cnt(v);
    bus_write(AD_FLG1, 16'h0010);
    bus_read(AD_FLG1, 16'h0010, "R9");
    bus_write(AD_MODE, 16'h0000);

    // First wrap, fast clear off
    bus_write(AD_CTRL, 16'h0002);
    wait_cnt(16'h0000);
    bus_read(AD_FLG2, 16'h0080, "R2 set");
    chk({15'b0, irq_ovf}, 16'h1, "R11 overflow");
    bus_read(AD_CNT, mcnt(), "R1 after wrap");
    bus_read(AD_FLG2, 16'h0080, "R4 no fast clear");
    bus_write(AD_FLG2, 16'h007F);
    bus_read(AD_FLG2, 16'h0080, "R3 zero bit");
    bus_write(AD_FLG2, 16'h0080);
    bus_read(AD_FLG2, 16'h0000, "R3 clear");
    chk({15'b0, irq_ovf}, 16'h0, "R11 overflow cleared");

    // Second wrap, fast clear on
    bus_write(AD_CTRL, 16'h0003);
    bus_read(AD_CTRL, 16'h0003, "R4 control");
    wait_cnt(16'h0000);
    bus_read(AD_FLG2, 16'h0080, "R2 second");
    bus_read(AD_CNT, mcnt(), "R4 counter read");
    bus_read(AD_FLG2, 16'h0000, "R4 cleared by read");
    bus_read(AD_FLG1, 16'h0010, "R4 channel flags kept");

    idle(3);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12 scoreboard: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule